// File: doc/BRIEF.md
# Little-Endian Byte/Word Load-Store Unit

This block carries out the memory half of byte and word loads and stores for a 16-bit processor. The issue stage hands it an instruction word and the values of the two registers named by fields [8:6] and [11:9]. The block works out which of those values is the base, adds the signed 4-bit offset from the instruction, and places a single request on a 16-bit memory port. The port has two byte-lane enables. For a load, the block returns the result already sign- or zero-extended, together with the destination register index, so the value can be written back directly.

The issue side is a valid/ready stream. `cmd_ready` is high only while the unit is idle. A command is taken on any rising edge where `cmd_valid` and `cmd_ready` are both high, and the issuer keeps it stable until that edge. The request side is also valid/ready. Once `mem_req_valid` is raised, the address, enables, write flag, data and I/O select stay frozen until the edge on which `mem_req_ready` is seen high. The read response comes as a one-cycle `mem_rsp_valid` strobe, no earlier than the cycle after the request handshake. The memory side exerts back-pressure through `mem_req_ready`. The issuer exerts none, because the completion pulses cannot be stalled.

The unit rejects two kinds of command: a word access with an odd address, and an instruction whose opcode or function code is not one of the five supported accesses. A rejected command produces a one-cycle fault pulse and no memory traffic. Any access that lands in the top 4 KiB of the address space is flagged on the I/O-select output, so the fabric can steer it to peripherals.

Top module: `lsu_le16`

## Requirements
- R1: The effective address is the base plus the sign-extended offset field [15:12], which spans -8 to +7, taken modulo 2^16. For stores the base is `cmd_reg_a` (field [8:6]). For loads the base is `cmd_reg_b` (field [11:9]).
- R2: Only five commands are accepted. With opcode [2:0]=011, func3 [5:3]=000 is a byte store and 001 is a word store. With opcode 100, func3 000 is a signed byte load, 001 is a word load and 100 is an unsigned byte load. Every other code raises `fault` and issues no request. `mem_we` is 1 for stores and 0 for loads.
- R3: A byte access at an even address uses `mem_be`=2'b01, and at an odd address it uses 2'b10. A byte store drives the low byte of `cmd_reg_b` onto both halves of `mem_wdata`.
- R4: A word store drives `mem_be`=2'b11 and `mem_wdata`=`cmd_reg_b`. The byte at the even address sits in bits [7:0] (little-endian).
- R5: A word access whose effective address is odd raises `fault` for exactly one cycle, in the cycle after acceptance. It issues no request and gives no `done`, and `cmd_ready` is high again in that same cycle.
- R6: Load results use the lane chosen by address bit 0: bits [7:0] when the bit is 0 and bits [15:8] when it is 1. A signed byte load sign-extends that byte, an unsigned byte load zero-extends it, and a word load returns all 16 bits. `wb_rd` equals field [8:6].
- R7: `mem_io_sel` is high with a request exactly when the effective address lies in 0xF000..0xFFFF.
- R8: `mem_req_valid` rises in the cycle after acceptance and holds its payload stable until the handshake. `cmd_ready` stays low from acceptance until the cycle after `done`.
- R9: `done` is a one-cycle pulse. It comes one cycle after the request handshake for a store, and one cycle after `mem_rsp_valid` for a load. `wb_en` is high with `done` for loads only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_insn | input | 16 | Instruction word |
| cmd_reg_a | input | 16 | Value of register named by [8:6] |
| cmd_reg_b | input | 16 | Value of register named by [11:9] |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 16 | Byte address |
| mem_we | output | 1 | 1 = write |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Write data, lane-steered |
| mem_io_sel | output | 1 | Address in I/O window |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 16 | Read data word |
| done | output | 1 | Access completed (pulse) |
| fault | output | 1 | Command rejected (pulse) |
| wb_en | output | 1 | Load result valid for write-back |
| wb_rd | output | 3 | Destination register index |
| wb_data | output | 16 | Extended load result |

## Verification
The bench takes a command at a rising edge and samples the outputs on the next falling edge. At that point the request payload (R1, R3, R4, R7) or the fault pulse (R2, R5) must already be visible, one register stage after acceptance. While `mem_req_ready` is held low for zero to two cycles, the bench re-samples the payload on every falling edge. After the ready edge, a store must show `done` on the very next falling edge. A load must show `done` and the extended data (R6) on the falling edge after the response strobe, which the bench delays by zero to two cycles. One further falling edge confirms that the pulse has dropped and the unit is idle again (R8, R9).

// File: rtl/lsu_le16_pkg.sv
package lsu_le16_pkg;
  localparam int XLEN   = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = XLEN / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int OFF_W  = 4;
  localparam int RIDX_W = 3;

  localparam logic [2:0] OPC_STORE = 3'b011;
  localparam logic [2:0] OPC_LOAD  = 3'b100;
  localparam logic [2:0] F3_BYTE   = 3'b000;
  localparam logic [2:0] F3_WORD   = 3'b001;
  localparam logic [2:0] F3_UBYTE  = 3'b100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } lsu_state_t;

  typedef struct packed {
    logic [XLEN-1:0]   addr;
    logic [LANES-1:0]  be;
    logic [XLEN-1:0]   wdata;
    logic              we;
    logic              io;
    logic [LANE_W-1:0] lane;
    logic              word;
    logic              sext;
    logic [RIDX_W-1:0] rd;
  } lsu_req_t;
endpackage

// File: rtl/lsu_le16_decode.sv
module lsu_le16_decode
  import lsu_le16_pkg::*;
#(
  parameter logic [XLEN-1:0] IO_BASE   = 16'hF000,
  parameter int              IO_SPAN_W = 12
) (
  input  logic [2:0]        opc,
  input  logic [2:0]        f3,
  input  logic [OFF_W-1:0]  off,
  input  logic [XLEN-1:0]   reg_a,
  input  logic [XLEN-1:0]   reg_b,
  output logic              legal,
  output logic              is_load,
  output logic              is_word,
  output logic              sext_ld,
  output logic              misalign,
  output logic              io_hit,
  output logic [XLEN-1:0]   eff_addr
);
  logic            is_store;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] off_x;

  always_comb begin
    is_store = (opc == OPC_STORE);
    is_load  = (opc == OPC_LOAD);
    legal    = 1'b0;
    is_word  = (f3 == F3_WORD);
    sext_ld  = (f3 == F3_BYTE);
    if (is_store) legal = (f3 == F3_BYTE) || (f3 == F3_WORD);
    if (is_load)  legal = (f3 == F3_BYTE) || (f3 == F3_WORD) || (f3 == F3_UBYTE);
  end

  assign base     = is_load ? reg_b : reg_a;
  assign off_x    = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
  assign eff_addr = base + off_x;
  assign misalign = is_word && (eff_addr[LANE_W-1:0] != '0);
  assign io_hit   = (eff_addr[XLEN-1:IO_SPAN_W] == IO_BASE[XLEN-1:IO_SPAN_W]);
endmodule

// File: rtl/lsu_le16_wlane.sv
module lsu_le16_wlane
  import lsu_le16_pkg::*;
(
  input  logic              is_word,
  input  logic [LANE_W-1:0] lane,
  input  logic [XLEN-1:0]   data,
  output logic [LANES-1:0]  be,
  output logic [XLEN-1:0]   wdata
);
  always_comb begin
    if (is_word) begin
      be    = '1;
      wdata = data;
    end else begin
      be    = LANES'(1) << lane;
      wdata = {LANES{data[BYTE_W-1:0]}};
    end
  end
endmodule

// File: rtl/lsu_le16_rlane.sv
module lsu_le16_rlane
  import lsu_le16_pkg::*;
(
  input  logic              is_word,
  input  logic              sext,
  input  logic [LANE_W-1:0] lane,
  input  logic [XLEN-1:0]   rdata,
  output logic [XLEN-1:0]   value
);
  logic [BYTE_W-1:0] byte_v;

  assign byte_v = rdata[lane*BYTE_W +: BYTE_W];

  always_comb begin
    if (is_word) value = rdata;
    else         value = {{(XLEN-BYTE_W){sext & byte_v[BYTE_W-1]}}, byte_v};
  end
endmodule

// File: rtl/lsu_le16.sv
module lsu_le16
  import lsu_le16_pkg::*;
#(
  parameter logic [15:0] IO_BASE   = 16'hF000,
  parameter int          IO_SPAN_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [15:0] cmd_insn,
  input  logic [15:0] cmd_reg_a,
  input  logic [15:0] cmd_reg_b,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [1:0]  mem_be,
  output logic [15:0] mem_wdata,
  output logic        mem_io_sel,
  input  logic        mem_rsp_valid,
  input  logic [15:0] mem_rsp_rdata,
  output logic        done,
  output logic        fault,
  output logic        wb_en,
  output logic [2:0]  wb_rd,
  output logic [15:0] wb_data
);
  lsu_state_t      state;
  lsu_req_t        req_q;
  logic            fault_q;
  logic [XLEN-1:0] wb_q;

  logic            d_legal, d_load, d_word, d_sext, d_mis, d_io;
  logic [XLEN-1:0] d_addr;
  logic [LANES-1:0] w_be;
  logic [XLEN-1:0] w_data;
  logic [XLEN-1:0] r_value;
  logic            accept;
  logic            unused_fields;

  assign unused_fields = ^cmd_insn[11:9];

  lsu_le16_decode #(
    .IO_BASE   (IO_BASE),
    .IO_SPAN_W (IO_SPAN_W)
  ) u_decode (
    .opc      (cmd_insn[2:0]),
    .f3       (cmd_insn[5:3]),
    .off      (cmd_insn[15:12]),
    .reg_a    (cmd_reg_a),
    .reg_b    (cmd_reg_b),
    .legal    (d_legal),
    .is_load  (d_load),
    .is_word  (d_word),
    .sext_ld  (d_sext),
    .misalign (d_mis),
    .io_hit   (d_io),
    .eff_addr (d_addr)
  );

  lsu_le16_wlane u_wlane (
    .is_word (d_word),
    .lane    (d_addr[LANE_W-1:0]),
    .data    (cmd_reg_b),
    .be      (w_be),
    .wdata   (w_data)
  );

  lsu_le16_rlane u_rlane (
    .is_word (req_q.word),
    .sext    (req_q.sext),
    .lane    (req_q.lane),
    .rdata   (mem_rsp_rdata),
    .value   (r_value)
  );

  assign accept = cmd_valid && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      req_q   <= '0;
      fault_q <= 1'b0;
      wb_q    <= '0;
    end else begin
      fault_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!d_legal || d_mis) begin
              fault_q <= 1'b1;
            end else begin
              req_q.addr  <= d_addr;
              req_q.be    <= w_be;
              req_q.wdata <= d_load ? '0 : w_data;
              req_q.we    <= !d_load;
              req_q.io    <= d_io;
              req_q.lane  <= d_addr[LANE_W-1:0];
              req_q.word  <= d_word;
              req_q.sext  <= d_sext;
              req_q.rd    <= cmd_insn[8:6];
              state       <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= req_q.we ? ST_DONE : ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            wb_q  <= r_value;
            state <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_addr      = req_q.addr;
  assign mem_we        = req_q.we;
  assign mem_be        = req_q.be;
  assign mem_wdata     = req_q.wdata;
  assign mem_io_sel    = req_q.io;
  assign done          = (state == ST_DONE);
  assign wb_en         = (state == ST_DONE) && !req_q.we;
  assign wb_rd         = req_q.rd;
  assign wb_data       = wb_q;
  assign fault         = fault_q;
endmodule

// File: rtl/lsu_le16_chk.sv
module lsu_le16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic [1:0]  mem_be,
  input logic [15:0] mem_wdata,
  input logic        mem_io_sel,
  input logic        done,
  input logic        fault,
  input logic        wb_en
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_be) && $stable(mem_wdata) && $stable(mem_we));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cmd_ready);

  assert_byte_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_be != 2'b11 |->
      mem_be == (mem_addr[0] ? 2'b10 : 2'b01));

  assert_byte_repl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we && mem_be != 2'b11 |->
      mem_wdata[15:8] == mem_wdata[7:0]);

  assert_word_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_be == 2'b11 |-> !mem_addr[0]);

  assert_fault_noreq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_req_valid && !done && cmd_ready);

  assert_io_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_io_sel == (mem_addr >= 16'hF000));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_wb_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done && !mem_we);
endmodule

bind lsu_le16 lsu_le16_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_addr      (mem_addr),
  .mem_we        (mem_we),
  .mem_be        (mem_be),
  .mem_wdata     (mem_wdata),
  .mem_io_sel    (mem_io_sel),
  .done          (done),
  .fault         (fault),
  .wb_en         (wb_en)
);

// File: tb/lsu_le16_tb.sv
module lsu_le16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_insn = '0;
  logic [15:0] cmd_reg_a = '0;
  logic [15:0] cmd_reg_b = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic        mem_io_sel;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_rdata = '0;
  logic        done, fault, wb_en;
  logic [2:0]  wb_rd;
  logic [15:0] wb_data;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  lsu_le16 u_dut (.*);

  task automatic chk(input bit ok, input string rq, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [2:0] f3,
                     input logic [3:0] off, input logic [2:0] ia,
                     input logic [2:0] ib, input logic [15:0] va,
                     input logic [15:0] vb, input int stall, input int lat);
    bit          st, ld, legal, word, bad, odd;
    int          offi;
    logic [15:0] base, ea, exp_wd, rdat, exp_wb;
    logic [1:0]  exp_be;
    logic [7:0]  bsel;
    st    = (op == 3'b011);
    ld    = (op == 3'b100);
    legal = (st && (f3 == 3'd0 || f3 == 3'd1)) ||
            (ld && (f3 == 3'd0 || f3 == 3'd1 || f3 == 3'd4));
    word  = (f3 == 3'd1);
    base  = st ? va : vb;
    offi  = off[3] ? int'(off) - 16 : int'(off);
    ea    = 16'(int'(base) + offi);
    odd   = ea[0];
    bad   = !legal || (word && odd);
    exp_be = word ? 2'b11 : (odd ? 2'b10 : 2'b01);
    exp_wd = word ? vb : {vb[7:0], vb[7:0]};

    chk(cmd_ready == 1'b1, "R8 ready before command", {15'd0, cmd_ready}, 16'd1);
    cmd_insn  = {off, ib, ia, f3, op};
    cmd_reg_a = va;
    cmd_reg_b = vb;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;

    if (bad) begin
      chk(fault == 1'b1, legal ? "R5 misaligned fault" : "R2 unsupported code fault",
          {15'd0, fault}, 16'd1);
      chk(mem_req_valid == 1'b0 && cmd_ready == 1'b1, legal ? "R5 no request" : "R2 no request",
          {14'd0, mem_req_valid, cmd_ready}, 16'd1);
      @(negedge clk);
      chk(fault == 1'b0 && done == 1'b0, "R5 fault single cycle", {14'd0, fault, done}, 16'd0);
      return;
    end

    chk(fault == 1'b0, "R2 legal no fault", {15'd0, fault}, 16'd0);
    chk(mem_req_valid == 1'b1, "R8 request after accept", {15'd0, mem_req_valid}, 16'd1);
    chk(mem_addr == ea, "R1 effective address", mem_addr, ea);
    chk(mem_we == st, "R2 write flag", {15'd0, mem_we}, {15'd0, st});
    chk(mem_be == exp_be, word ? "R4 word enables" : "R3 byte lane enables",
        {14'd0, mem_be}, {14'd0, exp_be});
    if (st) chk(mem_wdata == exp_wd, word ? "R4 word data" : "R3 byte data replicated",
                mem_wdata, exp_wd);
    chk(mem_io_sel == (ea >= 16'hF000), "R7 io select",
        {15'd0, mem_io_sel}, {15'd0, ea >= 16'hF000});

    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_addr == ea && mem_be == exp_be && !cmd_ready,
          "R8 hold under back-pressure", mem_addr, ea);
    end
    mem_req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_req_ready = 1'b0;

    if (st) begin
      chk(done == 1'b1 && wb_en == 1'b0, "R9 store done no writeback",
          {14'd0, done, wb_en}, 16'd2);
    end else begin
      for (int i = 0; i < lat; i++) begin
        chk(done == 1'b0 && mem_req_valid == 1'b0, "R9 load waits for data",
            {14'd0, done, mem_req_valid}, 16'd0);
        @(negedge clk);
      end
      rdat = (ea * 16'd40503) ^ 16'h5A5A;
      mem_rsp_valid = 1'b1;
      mem_rsp_rdata = rdat;
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_rdata = 16'h0000;
      bsel = odd ? rdat[15:8] : rdat[7:0];
      if (word)           exp_wb = rdat;
      else if (f3 == 3'd0) exp_wb = {{8{bsel[7]}}, bsel};
      else                exp_wb = {8'h00, bsel};
      chk(done == 1'b1 && wb_en == 1'b1, "R9 load done with writeback",
          {14'd0, done, wb_en}, 16'd3);
      chk(wb_data == exp_wb, "R6 load extension", wb_data, exp_wb);
      chk(wb_rd == ia, "R6 destination index", {13'd0, wb_rd}, {13'd0, ia});
    end

    @(negedge clk);
    chk(done == 1'b0 && cmd_ready == 1'b1, "R9 done single cycle",
        {14'd0, done, cmd_ready}, 16'd1);
  endtask

  initial begin
    logic [15:0] bases [6];
    logic [2:0]  ops   [5];
    logic [2:0]  f3s   [5];
    logic [2:0]  bop   [6];
    logic [2:0]  bf3   [6];
    bases = '{16'h0000, 16'h0001, 16'h7FF9, 16'hEFFE, 16'hF000, 16'hFFFF};
    ops   = '{3'b011, 3'b011, 3'b100, 3'b100, 3'b100};
    f3s   = '{3'd0, 3'd1, 3'd0, 3'd1, 3'd4};
    bop   = '{3'b011, 3'b011, 3'b100, 3'b100, 3'b000, 3'b111};
    bf3   = '{3'd2, 3'd7, 3'd2, 3'd7, 3'd0, 3'd1};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && mem_req_valid == 1'b0 && done == 1'b0 && fault == 1'b0,
        "R8 reset state", {12'd0, cmd_ready, mem_req_valid, done, fault}, 16'd8);

    for (int k = 0; k < 5; k++)
      for (int b = 0; b < 6; b++)
        for (int o = 0; o < 16; o++) begin
          logic [15:0] other, data;
          other = 16'h3C5A ^ 16'(o * 16'h0111);
          data  = 16'h80F1 ^ 16'(o * 16'h1111) ^ 16'(b << 5);
          if (ops[k] == 3'b011)
            run(ops[k], f3s[k], 4'(o), 3'(o), 3'(o + 3), bases[b], data, o % 3, (o >> 2) % 3);
          else
            run(ops[k], f3s[k], 4'(o), 3'(o), 3'(o + 3), other, bases[b], o % 3, (o >> 2) % 3);
        end

    for (int k = 0; k < 6; k++)
      for (int o = 0; o < 4; o++)
        run(bop[k], bf3[k], 4'(o * 5), 3'd1, 3'd2, 16'h1000, 16'h2000, 0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule